// File: doc/BRIEF.md
# Panel Register Write Sequencer over SPI

This block sets up a small TFT panel by writing its control registers over a write-only SPI link. A single-cycle command selects one of three power-state sequences: power-up, shutdown or resume. The block then performs one or two register writes in a fixed order, drives the serial clock, data and chip-select lines itself, and pulses a done flag when the last write has left the wire.

Every register write is sent as two framed transfers of three bytes each. The first frame carries the index, which names the register. The second frame carries the 16-bit value. Chip select goes high for one bit period after each frame. The serial clock is the system clock divided by a parameter. While a sequence is running the block reports busy, and it ignores any command presented during that time.

Top module: `panel_spi_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, spi_cs_n=1, spi_sclk=0, spi_mosi=0, busy=0 and done=0.
- R2: SPI mode 0. SCLK idles low. Each bit lasts CLK_DIV system cycles: CLK_DIV/2 cycles low followed by CLK_DIV/2 cycles high. MOSI holds the bit for the whole period. Bits go out most significant first, and 24 bits form one frame.
- R3: The index frame is the byte 0x74, then 0x00, then the 8-bit register number.
- R4: The data frame is the byte 0x76, then the value's high byte, then its low byte. Each index frame comes directly before its own data frame.
- R5: After every frame, spi_cs_n is high with SCLK low for exactly CLK_DIV cycles. Outside a sequence, spi_cs_n stays high.
- R6: cmd_op=2'b00 (power-up) first writes 0x0000 to register 0x11 and then writes the output word to register 0x01.
- R7: cmd_op=2'b10 (resume) first writes the output word to register 0x01 and then writes 0x0000 to register 0x11.
- R8: cmd_op=2'b01 and cmd_op=2'b11 (shutdown) each make exactly one write, of 0x0001 to register 0x11.
- R9: The output word is 0x00EF with cmd_mode[3] at bit 13, cmd_mode[2] at bit 11, cmd_mode[1] at bit 9 and cmd_mode[0] at bit 8. The mode is captured when the command is accepted.
- R10: A command is accepted when cmd_valid=1 and busy=0 at a clock edge. From that edge on, the outputs show the first bit, and busy stays high until the last gap ends. cmd_valid while busy has no effect.
- R11: In the cycle after the final gap, done is high for exactly one cycle and busy is low. A command presented in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Sequence select: 00 power-up, 01/11 shutdown, 10 resume |
| cmd_mode | input | 4 | Orientation and colour-order bits for the output word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The assertions assume that cmd_op and cmd_mode are settled whenever cmd_valid is high. They also assume that reset is held for at least one clock before the first check. The stimulus changes command inputs only on the falling clock edge and releases reset before issuing any command. It holds cmd_valid high during busy periods, and also across a done cycle, so that both the ignore rule and back-to-back acceptance are covered.

// File: rtl/panel_spi_pkg.sv
package panel_spi_pkg;

  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 3;
  localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
  localparam int VALUE_W     = 16;
  localparam int MODE_W      = 4;
  localparam int FIDX_W      = 2;

  typedef enum logic [1:0] {
    OP_POWER_UP = 2'b00,
    OP_SHUT     = 2'b01,
    OP_RESUME   = 2'b10,
    OP_SHUT_ALT = 2'b11
  } panel_op_e;

  localparam logic [BYTE_W-1:0]  LEAD_INDEX = 8'h74;
  localparam logic [BYTE_W-1:0]  LEAD_DATA  = 8'h76;
  localparam logic [BYTE_W-1:0]  REG_POWER  = 8'h11;
  localparam logic [BYTE_W-1:0]  REG_OUTCTL = 8'h01;
  localparam logic [VALUE_W-1:0] OUT_BASE   = 16'h2AEF;
  localparam logic [VALUE_W-1:0] OUT_MASK   = 16'h2B00;
  localparam logic [VALUE_W-1:0] VAL_ON     = 16'h0000;
  localparam logic [VALUE_W-1:0] VAL_OFF    = 16'h0001;

  function automatic logic [VALUE_W-1:0] out_word(input logic [MODE_W-1:0] m);
    logic [VALUE_W-1:0] w;
    w     = OUT_BASE & ~OUT_MASK;
    w[13] = m[3];
    w[11] = m[2];
    w[9]  = m[1];
    w[8]  = m[0];
    return w;
  endfunction

  function automatic logic [FIDX_W-1:0] last_frame(input logic [1:0] op);
    return (op == OP_POWER_UP || op == OP_RESUME) ? 2'd3 : 2'd1;
  endfunction

endpackage

// File: rtl/panel_wr_table.sv
module panel_wr_table
  import panel_spi_pkg::*;
(
  input  logic [1:0]            op,
  input  logic [MODE_W-1:0]     mode,
  input  logic [FIDX_W-1:0]     frame_idx,
  output logic [FRAME_BITS-1:0] frame_word
);
  logic               second_wr;
  logic               is_data;
  logic [BYTE_W-1:0]  reg_sel;
  logic [VALUE_W-1:0] val_sel;
  logic [VALUE_W-1:0] ctl;

  assign second_wr = frame_idx[1];
  assign is_data   = frame_idx[0];
  assign ctl       = out_word(mode);

  always_comb begin
    unique case (op)
      OP_POWER_UP: begin
        reg_sel = second_wr ? REG_OUTCTL : REG_POWER;
        val_sel = second_wr ? ctl : VAL_ON;
      end
      OP_RESUME: begin
        reg_sel = second_wr ? REG_POWER : REG_OUTCTL;
        val_sel = second_wr ? VAL_ON : ctl;
      end
      default: begin
        reg_sel = REG_POWER;
        val_sel = VAL_OFF;
      end
    endcase
  end

  assign frame_word = is_data ? {LEAD_DATA, val_sel}
                              : {LEAD_INDEX, {BYTE_W{1'b0}}, reg_sel};
endmodule

// File: rtl/panel_spi_slot_ctr.sv
module panel_spi_slot_ctr
  import panel_spi_pkg::*;
#(
  parameter int CLK_DIV = 8,
  localparam int PH_W   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1,
  localparam int BIT_W  = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FIDX_W-1:0] last_idx,
  output logic              act_n,
  output logic [PH_W-1:0]   ph_n,
  output logic [BIT_W-1:0]  bit_n,
  output logic [FIDX_W-1:0] fr_n,
  output logic              fin_n
);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] GAP_SLOT = BIT_W'(FRAME_BITS);

  logic              act_q;
  logic [PH_W-1:0]   ph_q;
  logic [BIT_W-1:0]  bit_q;
  logic [FIDX_W-1:0] fr_q;

  always_comb begin
    act_n = act_q;
    ph_n  = ph_q;
    bit_n = bit_q;
    fr_n  = fr_q;
    fin_n = 1'b0;
    if (!act_q) begin
      if (start) begin
        act_n = 1'b1;
        ph_n  = '0;
        bit_n = '0;
        fr_n  = '0;
      end
    end else if (ph_q == PH_LAST) begin
      ph_n = '0;
      if (bit_q == GAP_SLOT) begin
        bit_n = '0;
        if (fr_q == last_idx) begin
          act_n = 1'b0;
          fr_n  = '0;
          fin_n = 1'b1;
        end else begin
          fr_n = fr_q + 2'd1;
        end
      end else begin
        bit_n = bit_q + 1'b1;
      end
    end else begin
      ph_n = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      bit_q <= '0;
      fr_q  <= '0;
    end else begin
      act_q <= act_n;
      ph_q  <= ph_n;
      bit_q <= bit_n;
      fr_q  <= fr_n;
    end
  end

  assert_bit_bound_R2: assert property (@(posedge clk) disable iff (rst)
    bit_q <= GAP_SLOT);
  assert_frame_bound_R4: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (fr_q <= last_idx));
  assert_idle_counters_R5: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> (ph_q == '0 && bit_q == '0));
endmodule

// File: rtl/panel_spi_seq.sv
module panel_spi_seq
  import panel_spi_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [3:0] cmd_mode,
  output logic       busy,
  output logic       done,
  output logic       spi_sclk,
  output logic       spi_mosi,
  output logic       spi_cs_n
);
  localparam int PH_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS + 1);
  localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(CLK_DIV / 2);
  localparam logic [BIT_W-1:0] GAP_SLOT = BIT_W'(FRAME_BITS);
  localparam logic [BIT_W-1:0] TOP_BIT  = BIT_W'(FRAME_BITS - 1);

  logic              accept;
  logic [1:0]        op_q, op_n;
  logic [MODE_W-1:0] mode_q, mode_n;
  logic              act_n, fin_n;
  logic [PH_W-1:0]   ph_n;
  logic [BIT_W-1:0]  bit_n;
  logic [FIDX_W-1:0] fr_n;
  logic [FRAME_BITS-1:0] word_n;
  logic [BIT_W-1:0]  sel_bit;
  logic              frame_on;

  assign accept = cmd_valid && !busy;
  assign op_n   = accept ? cmd_op : op_q;
  assign mode_n = accept ? cmd_mode : mode_q;

  panel_spi_slot_ctr #(.CLK_DIV(CLK_DIV)) ctr_i (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .last_idx (last_frame(op_q)),
    .act_n    (act_n),
    .ph_n     (ph_n),
    .bit_n    (bit_n),
    .fr_n     (fr_n),
    .fin_n    (fin_n)
  );

  panel_wr_table tbl_i (
    .op         (op_n),
    .mode       (mode_n),
    .frame_idx  (fr_n),
    .frame_word (word_n)
  );

  assign frame_on = act_n && (bit_n != GAP_SLOT);
  assign sel_bit  = TOP_BIT - bit_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= OP_POWER_UP;
      mode_q   <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      spi_cs_n <= 1'b1;
      spi_sclk <= 1'b0;
      spi_mosi <= 1'b0;
    end else begin
      op_q     <= op_n;
      mode_q   <= mode_n;
      busy     <= act_n;
      done     <= fin_n;
      spi_cs_n <= !frame_on;
      spi_sclk <= frame_on && (ph_n >= PH_HALF);
      spi_mosi <= frame_on && word_n[sel_bit];
    end
  end

  assert_sclk_low_in_gap_R5: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);
  assert_cs_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_cs_n);
  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
  assert_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
endmodule

// File: tb/panel_spi_seq_tb_top.sv
module panel_spi_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;

  typedef struct {
    bit cs; bit sclk; bit mosi; bit busy; bit done; int tag;
  } slot_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [3:0] cmd_mode = 4'h0;
  logic busy, done, spi_sclk, spi_mosi, spi_cs_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_spi_seq #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_mode(cmd_mode), .busy(busy), .done(done), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  // reference model state
  slot_t q[$];
  slot_t cur = '{cs:1, sclk:0, mosi:0, busy:0, done:0, tag:1};
  logic [23:0] exp_frames[$];
  int          exp_tags[$];

  function automatic string tname(int t);
    case (t)
      1: return "R1"; 3: return "R3"; 4: return "R4"; 6: return "R6";
      7: return "R7"; 8: return "R8"; 9: return "R9"; default: return "R?";
    endcase
  endfunction

  function automatic logic [15:0] ctlw(logic [3:0] m);
    return 16'h00EF | (16'(m[3]) << 13) | (16'(m[2]) << 11)
                    | (16'(m[1]) << 9) | (16'(m[0]) << 8);
  endfunction

  task automatic add_write(logic [7:0] r, logic [15:0] v, int tg);
    logic [23:0] w;
    for (int f = 0; f < 2; f++) begin
      w = (f == 0) ? {8'h74, 8'h00, r} : {8'h76, v};
      exp_frames.push_back(w);
      exp_tags.push_back(f == 0 ? 3 : 4);
      for (int b = 23; b >= 0; b--)
        for (int c = 0; c < DIV; c++)
          q.push_back('{cs:0, sclk:(c >= DIV/2), mosi:w[b], busy:1, done:0, tag:tg});
      for (int c = 0; c < DIV; c++)
        q.push_back('{cs:1, sclk:0, mosi:0, busy:1, done:0, tag:tg});
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      cur = '{cs:1, sclk:0, mosi:0, busy:0, done:0, tag:1};
    end else begin
      if (cmd_valid && !cur.busy) begin
        case (cmd_op)
          2'b00: begin add_write(8'h11, 16'h0000, 6); add_write(8'h01, ctlw(cmd_mode), 9); end
          2'b10: begin add_write(8'h01, ctlw(cmd_mode), 7); add_write(8'h11, 16'h0000, 7); end
          default: add_write(8'h11, 16'h0001, 8);
        endcase
        q.push_back('{cs:1, sclk:0, mosi:0, busy:0, done:1, tag:9});
      end
      if (q.size() > 0) cur = q.pop_front();
      else cur = '{cs:1, sclk:0, mosi:0, busy:0, done:0, tag:1};
    end
  end

  task automatic chk(bit act, bit exp, string req, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // frame decoder
  logic [23:0] shreg = '0;
  int nbits = 0;
  bit prev_sclk = 0, prev_cs = 1;

  always @(negedge clk) begin
    if (!finished) begin
      if (rst) begin
        chk(spi_cs_n, 1'b1, "R1", "cs_n"); chk(spi_sclk, 1'b0, "R1", "sclk");
        chk(spi_mosi, 1'b0, "R1", "mosi"); chk(busy, 1'b0, "R1", "busy");
        chk(done, 1'b0, "R1", "done");
      end else begin
        chk(spi_cs_n, cur.cs, "R5", "cs_n");
        chk(spi_sclk, cur.sclk, "R2", "sclk");
        chk(spi_mosi, cur.mosi, tname(cur.tag), "mosi");
        chk(busy, cur.busy, "R10", "busy");
        chk(done, cur.done, "R11", "done");
        if (!spi_cs_n && spi_sclk && !prev_sclk) begin
          shreg = {shreg[22:0], spi_mosi};
          nbits++;
        end
        if (spi_cs_n && !prev_cs) begin
          logic [23:0] ef; int et;
          ef = (exp_frames.size() > 0) ? exp_frames.pop_front() : 24'hxxxxxx;
          et = (exp_tags.size() > 0) ? exp_tags.pop_front() : 3;
          checks++;
          if (shreg !== ef || nbits != 24) begin
            errors++;
            $display("FAIL %s frame actual=%h/%0d bits expected=%h/24",
                     tname(et), shreg, nbits, ef);
          end
          nbits = 0;
        end
      end
      prev_sclk = spi_sclk;
      prev_cs   = spi_cs_n;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (cur.busy || q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(logic [1:0] op, logic [3:0] m);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_mode = m;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    issue(2'b00, 4'h0);   // R6 power-up, mode zero
    issue(2'b10, 4'hF);   // R7 resume, all mode bits (R9)
    issue(2'b01, 4'h5);   // R8 shutdown
    issue(2'b11, 4'hA);   // R8 shutdown alternate code
    issue(2'b00, 4'h6);   // R9 mixed mode bits
    // R10: commands while busy are ignored; R11: held request taken at done
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_mode = 4'h9;
    @(negedge clk);
    cmd_op = 2'b01; cmd_mode = 4'h3;
    while (!cur.done) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    checks++;
    if (exp_frames.size() != 0) begin
      errors++;
      $display("FAIL R4 leftover frames actual=%0d expected=0", exp_frames.size());
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule